// File: doc/BRIEF.md
# Conversion-Framed Serial Result Transmitter

This block is the digital output stage of a sampling converter. A rising edge on `conv_start` starts a conversion. On that edge the block captures the parallel `result` word and sends it as a framed serial word. The word has `PAD_W` zero bits followed by the `RES_W`-bit result, most significant bit first. One register then walks the word out on a data line, next to a serial clock and an active-low frame strobe.

All three serial lines are open-drain. Each one is brought out as a single enable: 1 pulls the line low, and 0 releases it to the external pull-up, which reads as high. The serial clock runs at half the master clock rate. When `free_run` is low, the serial clock is driven only while a frame is in progress and is released at all other times, so several transmitters can share one bus. When `free_run` is high, the serial clock toggles on every master clock cycle, including between frames. `busy` is high from the start of conversion until the frame strobe is released.

Top module: `conv_serial_tx`

## Requirements
- R1: After reset, `sclk_oe`, `strb_oe`, `data_oe` and `busy` are all 0.
- R2: A low-to-high change of `conv_start` seen at a clock edge while idle starts a frame at that edge: `busy` and `strb_oe` are 1 after it. `result` is captured at that edge, and later changes of `result` do not alter the frame.
- R3: A frame carries 16 bits. Bits 1 to 4 are 0, and bits 5 to 16 are `result[11]` down to `result[0]`. Bit n is the data line level at the n-th falling edge of the serial clock within the frame.
- R4: While a frame is in progress, the data line changes only when the serial clock rises. It holds steady across every falling edge.
- R5: The serial clock line (level = !`sclk_oe`) is high during the first clock of a frame and then alternates every master clock. The frame strobe and `busy` drop to 0 on the clock after the 16th falling edge, which is 32 clocks after the start edge.
- R6: When `free_run` = 0, `sclk_oe` is 0 whenever `busy` is 0.
- R7: When `free_run` = 1, `sclk_oe` changes value on every clock, except at a frame start, where the line is forced high.
- R8: A `conv_start` rising edge during a frame is ignored. The frame in progress keeps its timing and contents.
- R9: The encoding is open-drain: an enable of 1 means the line is low. `data_oe` is 1 only while `busy` is 1 and the current bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion start; a rising edge begins a frame |
| free_run | input | 1 | 1: serial clock always toggles; 0: serial clock gated to the frame |
| result | input | RES_W | Parallel conversion result, captured at frame start |
| sclk_oe | output | 1 | Serial clock pull-down enable |
| strb_oe | output | 1 | Frame strobe pull-down enable (strobe active low) |
| data_oe | output | 1 | Data line pull-down enable |
| busy | output | 1 | Conversion/frame in progress |

## Verification
The in-module assertions check these properties on every cycle:
- zero pad bits at the head of the frame;
- data held steady across falling serial clock edges;
- a frame length of exactly 16 falling edges;
- the serial clock released when idle in gated mode, and toggling in free-running mode;
- a start edge during a frame leaving the fall count running on.

The bench's scenarios cover what only whole frames can show: that the received word equals the captured result for varied bit patterns, and that a changed `result` after the start edge has no effect. They also show that a retrigger in mid-frame yields neither a second frame nor a changed word, and that the strobe is released exactly 32 clocks after the start edge.

// File: rtl/conv_serial_tx.sv
module conv_serial_tx #(
  parameter int RES_W = 12,
  parameter int PAD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             free_run,
  input  logic [RES_W-1:0] result,
  output logic             sclk_oe,
  output logic             strb_oe,
  output logic             data_oe,
  output logic             busy
);

  localparam int WORD_W = RES_W + PAD_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(WORD_W);

  logic              start_q;
  logic              ph;
  logic [CNT_W-1:0]  falls;
  logic [WORD_W-1:0] sh;

  wire start_rise = conv_start & ~start_q;
  wire load       = start_rise & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy    <= 1'b0;
      ph      <= 1'b1;
      falls   <= '0;
      sh      <= '0;
    end else begin
      start_q <= conv_start;
      if (load) begin
        busy  <= 1'b1;
        ph    <= 1'b1;
        falls <= '0;
        sh    <= {{PAD_W{1'b0}}, result};
      end else begin
        ph <= (busy | free_run) ? ~ph : 1'b1;
        if (busy) begin
          if (ph)                       falls <= falls + 1'b1;
          else if (falls == LAST_FALL)  busy  <= 1'b0;
          else                          sh    <= {sh[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sclk_oe = (busy | free_run) & ~ph;
  assign strb_oe = busy;
  assign data_oe = busy & ~sh[WORD_W-1];

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && falls < CNT_W'(PAD_W)) |-> data_oe);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sclk_oe && falls != LAST_FALL) |=> $stable(data_oe));

  p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(falls) == LAST_FALL);

  p_idle_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && !busy) |-> !sclk_oe);

  p_free_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (free_run && $past(free_run)) |-> ($rose(busy) || sclk_oe != $past(sclk_oe)));

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_rise && ph) |=> (busy && falls == $past(falls) + 1'b1));

endmodule

// File: tb/conv_serial_tx_bench.sv
module conv_serial_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic        free_run = 1'b0;
  logic [11:0] result = '0;
  logic        sclk_oe, strb_oe, data_oe, busy;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  conv_serial_tx u_conv_serial_tx (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .free_run(free_run),
    .result(result), .sclk_oe(sclk_oe), .strb_oe(strb_oe),
    .data_oe(data_oe), .busy(busy)
  );

  localparam logic [12:0] VEC [8] = '{
    {1'b0, 12'hA5C}, {1'b0, 12'hFFF}, {1'b0, 12'h000}, {1'b0, 12'h801},
    {1'b1, 12'h3C7}, {1'b1, 12'h555}, {1'b1, 12'hAAA}, {1'b1, 12'h001}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input bit mode, input logic [11:0] res, input bit retrig);
    logic [15:0] word;
    int nbits, nclk;
    bit prev_line, line;
    @(negedge clk);
    free_run = mode;
    result = res;
    repeat (3) @(negedge clk);
    conv_start = 1'b1;
    word = '0; nbits = 0; nclk = 0; prev_line = 1'b1;
    @(negedge clk);
    check(busy && strb_oe, "R2", {busy, strb_oe}, 3);
    check(!sclk_oe, "R5", sclk_oe, 0);
    while (strb_oe && nclk < 100) begin
      line = ~sclk_oe;
      if (prev_line && !line) begin
        word = {word[14:0], ~data_oe};
        nbits++;
      end
      prev_line = line;
      nclk++;
      if (nclk == 2) result = ~res;
      if (nclk == 4) conv_start = 1'b0;
      if (retrig && nclk == 10) conv_start = 1'b1;
      if (retrig && nclk == 14) conv_start = 1'b0;
      @(negedge clk);
    end
    check(nclk == 32, "R5", nclk, 32);
    check(nbits == 16, "R3", nbits, 16);
    check(word == {4'b0, res}, "R3", word, {4'b0, res});
    check(!busy, "R5", busy, 0);
    if (retrig) begin
      repeat (4) @(negedge clk);
      check(!busy && !strb_oe, "R8", {busy, strb_oe}, 0);
    end
    conv_start = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit p;
    repeat (3) @(negedge clk);
    check({sclk_oe, strb_oe, data_oe, busy} == 4'b0, "R1",
          {sclk_oe, strb_oe, data_oe, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({sclk_oe, strb_oe, data_oe, busy} == 4'b0, "R1",
          {sclk_oe, strb_oe, data_oe, busy}, 0);

    for (int i = 0; i < 8; i++) run_frame(VEC[i][12], VEC[i][11:0], 1'b0);

    // R6: gated clock released while idle
    free_run = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!sclk_oe && !data_oe, "R6", {sclk_oe, data_oe}, 0);
    end

    // R7: free-running clock toggles while idle
    free_run = 1'b1;
    @(negedge clk);
    p = sclk_oe;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(sclk_oe != p, "R7", sclk_oe, !p);
      p = sclk_oe;
    end

    // R8: retrigger during a frame
    run_frame(1'b0, 12'h9E1, 1'b1);
    run_frame(1'b1, 12'h16B, 1'b1);

    // R9: data released when idle
    @(negedge clk);
    check(!data_oe && !strb_oe, "R9", {data_oe, strb_oe}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule